// File: doc/BRIEF.md
# DDR SDRAM Access and Refresh Sequencer

This block is the command state machine of a DDR SDRAM controller. It turns single host requests into complete command sequences on the memory command pins. It also decides when periodic refresh runs. Each access opens a row with ACTIVE. After the row-to-column delay it issues READ or WRITE with auto precharge set, so every bank is idle again once an access ends. Refresh therefore never needs a separate precharge.

The host holds `host_req_i` together with the direction, bank, row and column until it sees a completion pulse on `rd_ack_o` or `wr_ack_o`. A new request may follow in the next cycle. An internal down-counter raises `ref_req_o` at a fixed interval. A pending refresh wins over a waiting host request. While the refresh runs, `ref_ack_o` stays high. Strobes tell the data path when read data arrives and when write data must be driven. Nothing leaves the idle state until `init_done_i` is high.

Top module: `ddr_cmd_ctrl`

## Requirements
- R1: While `init_done_i` is low after reset, the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1). No acknowledge is asserted, and `host_req_i` is ignored.
- R2: A host request seen in an idle cycle with no refresh pending produces ACTIVE (cs_n,ras_n,cas_n,we_n = 0,0,1,1) in the next cycle. ACTIVE carries the bank on `ba_o` and the row on the low bits of `addr_o`.
- R3: READ (0,1,0,1) or WRITE (0,1,0,0) comes exactly T_RCD cycles after ACTIVE, to the same bank. It carries the column on the low bits of `addr_o`, with `addr_o[10]` high to request auto precharge.
- R4: For a read, `rd_capture_o` is high for BURST_LEN/2 consecutive cycles, starting CAS_LAT cycles after READ. `rd_ack_o` pulses for one cycle, in the last of those cycles.
- R5: For a write, `wr_drive_o` is high for BURST_LEN/2 cycles, starting the cycle after WRITE. Then T_WR recovery cycles follow, and `wr_ack_o` pulses in the last of them.
- R6: Each access issues exactly one ACTIVE and one READ or WRITE. Every other cycle of the access, recovery included, shows NOP.
- R7: `ref_req_o` first rises after REF_PERIOD-1 clock edges following reset release. While the block is idle, consecutive AUTO REFRESH commands (0,0,0,1) are exactly REF_PERIOD+T_RFC cycles apart.
- R8: A refresh pending in an idle cycle wins over a simultaneous host request. AUTO REFRESH is issued first, and `ref_ack_o` goes high in that cycle and stays high for exactly T_RFC cycles. No ACTIVE appears while `ref_ack_o` is high.
- R9: A refresh request raised during a host access stays asserted until the access ends. It is served at the next idle cycle, ahead of any waiting host request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | Device initialization finished |
| host_req_i | input | 1 | Host access request, held until acknowledge |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_bank_i | input | BANK_W | Bank of the access |
| host_row_i | input | ROW_W | Row of the access |
| host_col_i | input | COL_W | Starting column of the access |
| ref_req_o | output | 1 | Refresh interval elapsed, refresh pending |
| ref_ack_o | output | 1 | Refresh cycle in progress |
| rd_ack_o | output | 1 | Read complete pulse |
| wr_ack_o | output | 1 | Write complete pulse |
| rd_capture_o | output | 1 | Read data arriving, capture window |
| wr_drive_o | output | 1 | Write data drive window |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank address |
| addr_o | output | ADDR_W | Row or column address, bit 10 = auto precharge |

## Verification
The hardest case to reach from the ports is a refresh request that becomes due while an access is running. The request has to survive to the end of the access and then win over a host request that is already waiting. The bench issues long back-to-back runs of reads and writes against a shortened refresh interval, so this overlap happens many times. At each new request it compares the idle-cycle refresh flag with what appears on the command bus. A directed case also waits for the exact cycle in which `ref_req_o` rises while idle, and raises a host request in that same cycle.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACT,
    ST_RCD,
    ST_RD,
    ST_CL,
    ST_RDATA,
    ST_WR,
    ST_WDATA,
    ST_WREC,
    ST_REF,
    ST_RFC
  } state_e;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_READ,
    CMD_WRITE,
    CMD_AREF
  } cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_NOP   = '{1'b0, 1'b1, 1'b1, 1'b1};
  localparam pins_t PINS_ACT   = '{1'b0, 1'b0, 1'b1, 1'b1};
  localparam pins_t PINS_READ  = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam pins_t PINS_WRITE = '{1'b0, 1'b1, 1'b0, 1'b0};
  localparam pins_t PINS_AREF  = '{1'b0, 1'b0, 1'b0, 1'b1};

  // address bit that requests auto precharge on column commands
  localparam int AP_BIT = 10;

endpackage

// File: rtl/ddr_ref_timer.sv
module ddr_ref_timer #(
  parameter int PERIOD = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  output logic req_o
);
  localparam int W = $clog2(PERIOD + 1);
  localparam logic [W-1:0] START = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= START;
    else if (reload_i)        cnt_q <= START;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // held until the refresh finishes and reloads the count
  assign req_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_wait_cnt.sv
module ddr_wait_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_cmd_enc.sv
module ddr_cmd_enc
  import ddr_cmd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13
) (
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output pins_t             pins_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  // column must stay below the auto-precharge bit
  localparam int COL_USE = (COL_W > AP_BIT) ? AP_BIT : COL_W;

  always_comb begin
    pins_o = PINS_NOP;
    ba_o   = '0;
    addr_o = '0;
    unique case (cmd_i)
      CMD_ACT: begin
        pins_o = PINS_ACT;
        ba_o   = bank_i;
        addr_o[ROW_W-1:0] = row_i;
      end
      CMD_READ, CMD_WRITE: begin
        pins_o = (cmd_i == CMD_READ) ? PINS_READ : PINS_WRITE;
        ba_o   = bank_i;
        addr_o[COL_USE-1:0] = col_i[COL_USE-1:0];
        addr_o[AP_BIT] = 1'b1;
      end
      CMD_AREF: pins_o = PINS_AREF;
      default:  pins_o = PINS_NOP;
    endcase
  end

endmodule

// File: rtl/ddr_cmd_ctrl.sv
module ddr_cmd_ctrl
  import ddr_cmd_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 13,
  parameter int COL_W      = 10,
  parameter int ADDR_W     = 13,
  parameter int T_RCD      = 3,
  parameter int CAS_LAT    = 2,
  parameter int T_WR       = 2,
  parameter int T_RFC      = 8,
  parameter int BURST_LEN  = 4,
  parameter int REF_PERIOD = 780
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_done_i,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [BANK_W-1:0] host_bank_i,
  input  logic [ROW_W-1:0]  host_row_i,
  input  logic [COL_W-1:0]  host_col_i,
  output logic              ref_req_o,
  output logic              ref_ack_o,
  output logic              rd_ack_o,
  output logic              wr_ack_o,
  output logic              rd_capture_o,
  output logic              wr_drive_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int DATA_CYC = BURST_LEN / 2;
  // cycles spent in each wait state
  localparam int RCD_D = T_RCD - 1;
  localparam int CL_D  = CAS_LAT - 1;
  localparam int RFC_D = T_RFC - 1;
  localparam int MAX_A = (T_RCD > CAS_LAT) ? T_RCD : CAS_LAT;
  localparam int MAX_B = (T_WR > T_RFC) ? T_WR : T_RFC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_V = (MAX_C > DATA_CYC) ? MAX_C : DATA_CYC;
  localparam int CNT_W = $clog2(MAX_V + 1);
  localparam logic [CNT_W-1:0] RCD_L = CNT_W'((RCD_D > 0) ? RCD_D - 1 : 0);
  localparam logic [CNT_W-1:0] CL_L  = CNT_W'((CL_D > 0) ? CL_D - 1 : 0);
  localparam logic [CNT_W-1:0] RFC_L = CNT_W'((RFC_D > 0) ? RFC_D - 1 : 0);
  localparam logic [CNT_W-1:0] DAT_L = CNT_W'(DATA_CYC - 1);
  localparam logic [CNT_W-1:0] WR_L  = CNT_W'(T_WR - 1);

  state_e            state_q, state_d;
  logic              we_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              accept;
  logic              ld;
  logic [CNT_W-1:0]  ld_val;
  logic              wait_done;
  logic              ref_reload;
  logic              fsm_idle;
  cmd_e              cmd;
  pins_t             pins;

  ddr_ref_timer #(.PERIOD(REF_PERIOD)) u_ref_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(ref_reload),
    .req_o   (ref_req_o)
  );

  ddr_wait_cnt #(.W(CNT_W)) u_wait_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ld),
    .val_i (ld_val),
    .done_o(wait_done)
  );

  always_comb begin
    state_d    = state_q;
    accept     = 1'b0;
    ld         = 1'b0;
    ld_val     = '0;
    ref_reload = 1'b0;
    rd_ack_o   = 1'b0;
    wr_ack_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (init_done_i) begin
          if (ref_req_o) begin
            state_d = ST_REF;
          end else if (host_req_i) begin
            state_d = ST_ACT;
            accept  = 1'b1;
          end
        end
      end
      ST_ACT: begin
        if (RCD_D > 0) begin
          state_d = ST_RCD;
          ld      = 1'b1;
          ld_val  = RCD_L;
        end else begin
          state_d = we_q ? ST_WR : ST_RD;
        end
      end
      ST_RCD: if (wait_done) state_d = we_q ? ST_WR : ST_RD;
      ST_RD: begin
        ld = 1'b1;
        if (CL_D > 0) begin
          state_d = ST_CL;
          ld_val  = CL_L;
        end else begin
          state_d = ST_RDATA;
          ld_val  = DAT_L;
        end
      end
      ST_CL: begin
        if (wait_done) begin
          state_d = ST_RDATA;
          ld      = 1'b1;
          ld_val  = DAT_L;
        end
      end
      ST_RDATA: begin
        if (wait_done) begin
          state_d  = ST_IDLE;
          rd_ack_o = 1'b1;
        end
      end
      ST_WR: begin
        state_d = ST_WDATA;
        ld      = 1'b1;
        ld_val  = DAT_L;
      end
      ST_WDATA: begin
        if (wait_done) begin
          state_d = ST_WREC;
          ld      = 1'b1;
          ld_val  = WR_L;
        end
      end
      ST_WREC: begin
        if (wait_done) begin
          state_d  = ST_IDLE;
          wr_ack_o = 1'b1;
        end
      end
      ST_REF: begin
        if (RFC_D > 0) begin
          state_d = ST_RFC;
          ld      = 1'b1;
          ld_val  = RFC_L;
        end else begin
          state_d    = ST_IDLE;
          ref_reload = 1'b1;
        end
      end
      ST_RFC: begin
        if (wait_done) begin
          state_d    = ST_IDLE;
          ref_reload = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (accept) begin
      we_q   <= host_we_i;
      bank_q <= host_bank_i;
      row_q  <= host_row_i;
      col_q  <= host_col_i;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ACT:  cmd = CMD_ACT;
      ST_RD:   cmd = CMD_READ;
      ST_WR:   cmd = CMD_WRITE;
      ST_REF:  cmd = CMD_AREF;
      default: cmd = CMD_NOP;
    endcase
  end

  ddr_cmd_enc #(
    .BANK_W(BANK_W),
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .ADDR_W(ADDR_W)
  ) u_cmd_enc (
    .cmd_i (cmd),
    .bank_i(bank_q),
    .row_i (row_q),
    .col_i (col_q),
    .pins_o(pins),
    .ba_o  (ba_o),
    .addr_o(addr_o)
  );

  assign cs_n_o       = pins.cs_n;
  assign ras_n_o      = pins.ras_n;
  assign cas_n_o      = pins.cas_n;
  assign we_n_o       = pins.we_n;
  assign rd_capture_o = (state_q == ST_RDATA);
  assign wr_drive_o   = (state_q == ST_WDATA);
  assign ref_ack_o    = (state_q == ST_REF) || (state_q == ST_RFC);
  assign fsm_idle     = (state_q == ST_IDLE);

endmodule

// File: rtl/ddr_cmd_ctrl_chk.sv
module ddr_cmd_ctrl_chk #(
  parameter int ADDR_W = 13,
  parameter int T_RCD  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_done_i,
  input logic              idle_i,
  input logic              cs_n_i,
  input logic              ras_n_i,
  input logic              cas_n_i,
  input logic              we_n_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_ack_i,
  input logic              wr_ack_i,
  input logic              rd_capture_i,
  input logic              wr_drive_i,
  input logic              ref_ack_i,
  input logic              ref_req_i
);
  logic       is_nop, is_act, is_rdwr, is_aref;
  logic [7:0] gap_q;

  assign is_nop  = !cs_n_i && ras_n_i && cas_n_i && we_n_i;
  assign is_act  = !cs_n_i && !ras_n_i && cas_n_i && we_n_i;
  assign is_rdwr = !cs_n_i && ras_n_i && !cas_n_i;
  assign is_aref = !cs_n_i && !ras_n_i && !cas_n_i && we_n_i;

  // cycles since the last ACTIVE, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             gap_q <= 8'hff;
    else if (is_act)         gap_q <= 8'd1;
    else if (gap_q != 8'hff) gap_q <= gap_q + 8'd1;
  end

  p_init_nop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && !init_done_i) |=> is_nop);

  p_rcd_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rdwr |-> (gap_q == 8'(T_RCD)));

  p_auto_pre_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rdwr |-> addr_i[10]);

  p_rd_ack_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_i |-> rd_capture_i);

  p_rd_ack_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_i |=> !rd_ack_i);

  p_acks_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_ack_i, wr_ack_i, ref_ack_i}));

  p_wr_drive_nop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drive_i |-> is_nop);

  p_wr_ack_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_i |=> !wr_ack_i);

  p_ref_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_i && !ref_ack_i) |=> ref_req_i);

  p_aref_starts_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_aref |-> $rose(ref_ack_i));

  p_no_act_in_ref_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack_i |-> !is_act);

endmodule

bind ddr_cmd_ctrl ddr_cmd_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .T_RCD (T_RCD)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_done_i (init_done_i),
  .idle_i      (fsm_idle),
  .cs_n_i      (cs_n_o),
  .ras_n_i     (ras_n_o),
  .cas_n_i     (cas_n_o),
  .we_n_i      (we_n_o),
  .addr_i      (addr_o),
  .rd_ack_i    (rd_ack_o),
  .wr_ack_i    (wr_ack_o),
  .rd_capture_i(rd_capture_o),
  .wr_drive_i  (wr_drive_o),
  .ref_ack_i   (ref_ack_o),
  .ref_req_i   (ref_req_o)
);

// File: tb/ddr_cmd_ctrl_tb.sv
module ddr_cmd_ctrl_tb;
  localparam int T_RCD = 3;
  localparam int CL    = 2;
  localparam int T_WR  = 2;
  localparam int T_RFC = 8;
  localparam int BL    = 4;
  localparam int REF_P = 120;
  localparam int DCYC  = BL / 2;

  localparam logic [3:0] P_NOP  = 4'b0111;
  localparam logic [3:0] P_ACT  = 4'b0011;
  localparam logic [3:0] P_RD   = 4'b0101;
  localparam logic [3:0] P_WR   = 4'b0100;
  localparam logic [3:0] P_AREF = 4'b0001;

  typedef logic [18:0] item_t; // {pins, bank, addr}

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_done = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_bank = '0;
  logic [12:0] host_row = '0;
  logic [9:0]  host_col = '0;
  logic        ref_req, ref_ack, rd_ack, wr_ack, rd_cap, wr_drv;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  bit    idle_phase = 1'b0;
  bit    ref_mid = 1'b0;
  int    n_r9 = 0;
  item_t exp_q[$];

  ddr_cmd_ctrl #(.REF_PERIOD(REF_P)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init_done),
    .host_req_i(host_req), .host_we_i(host_we), .host_bank_i(host_bank),
    .host_row_i(host_row), .host_col_i(host_col),
    .ref_req_o(ref_req), .ref_ack_o(ref_ack), .rd_ack_o(rd_ack),
    .wr_ack_o(wr_ack), .rd_capture_o(rd_cap), .wr_drive_o(wr_drv),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr)
  );

  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] pins_now();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  // monitor: command scoreboard and refresh timing
  int  last_aref = -1;
  bit  last_aref_idle = 1'b0;
  int  ack_run = 0;
  bit  first_req_seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ref_req && !first_req_seen) begin
        first_req_seen = 1'b1;
        chk(cyc == REF_P - 1, "R7", "first refresh request cycle", cyc, REF_P - 1);
      end
      if (ref_ack) ack_run++;
      else if (ack_run > 0) begin
        chk(ack_run == T_RFC, "R8", "ref_ack length", ack_run, T_RFC);
        ack_run = 0;
      end
      if (pins_now() == P_AREF) begin
        chk(ref_ack, "R8", "ref_ack with AUTO REFRESH", ref_ack, 1);
        if (idle_phase && last_aref_idle)
          chk(cyc - last_aref == REF_P + T_RFC, "R7", "idle refresh spacing",
              cyc - last_aref, REF_P + T_RFC);
        last_aref = cyc;
        last_aref_idle = idle_phase;
      end else if (pins_now() != P_NOP) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected command", pins_now(), P_NOP);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk({pins_now(), ba, addr} == e, (e[18:15] == P_ACT) ? "R2" : "R3",
              "command/bank/address", {pins_now(), ba, addr}, e);
        end
      end
    end
  end

  // driver: called just after a negedge; FSM is idle in this cycle
  task automatic access(input bit wr, input logic [1:0] b,
                        input logic [12:0] r, input logic [9:0] c);
    int  t0, t_act, t_cmd, t_aref, cap_first, cap_n, drv_first, drv_n, t_ack;
    int  extra;
    bit  ref_pend;
    exp_q.push_back({P_ACT, b, r});
    exp_q.push_back({wr ? P_WR : P_RD, b, 13'(c) | 13'h400});
    host_we = wr; host_bank = b; host_row = r; host_col = c;
    host_req = 1'b1;
    t0 = cyc;
    ref_pend = ref_req;
    if (ref_mid) begin
      chk(ref_req, "R9", "refresh request held to idle", ref_req, 1);
      n_r9++;
      ref_mid = 1'b0;
    end
    t_act = -1; t_cmd = -1; t_aref = -1; cap_first = -1; cap_n = 0;
    drv_first = -1; drv_n = 0; t_ack = -1; extra = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pins_now() == P_AREF && t_aref < 0) t_aref = cyc;
      if (pins_now() == P_ACT && t_act < 0) t_act = cyc;
      else if ((pins_now() == P_RD || pins_now() == P_WR) && t_cmd < 0) t_cmd = cyc;
      else if (t_cmd >= 0 && pins_now() != P_NOP) extra++;
      if (t_act >= 0 && ref_req) ref_mid = 1'b1;
      if (rd_cap) begin if (cap_first < 0) cap_first = cyc; cap_n++; end
      if (wr_drv) begin if (drv_first < 0) drv_first = cyc; drv_n++; end
      if (rd_ack || wr_ack) begin
        t_ack = cyc;
        chk(wr ? wr_ack : rd_ack, wr ? "R5" : "R4", "ack kind", {rd_ack, wr_ack}, wr ? 1 : 2);
        break;
      end
    end
    host_req = 1'b0;
    chk(t_ack >= 0, wr ? "R5" : "R4", "ack seen", t_ack, 0);
    if (ref_pend) begin
      chk(t_aref == t0 + 1, "R8", "refresh before host", t_aref, t0 + 1);
      chk(t_act == t0 + T_RFC + 2, "R8", "ACTIVE after refresh", t_act, t0 + T_RFC + 2);
    end else begin
      chk(t_act == t0 + 1, "R2", "ACTIVE latency", t_act, t0 + 1);
    end
    chk(t_cmd - t_act == T_RCD, "R3", "ACTIVE to column gap", t_cmd - t_act, T_RCD);
    chk(extra == 0, "R6", "non-NOP after column command", extra, 0);
    if (!wr) begin
      chk(cap_first == t_cmd + CL, "R4", "capture start", cap_first, t_cmd + CL);
      chk(cap_n == DCYC, "R4", "capture length", cap_n, DCYC);
      chk(t_ack == cap_first + DCYC - 1, "R4", "read ack cycle", t_ack, cap_first + DCYC - 1);
      chk(drv_n == 0, "R4", "no drive on read", drv_n, 0);
    end else begin
      chk(drv_first == t_cmd + 1, "R5", "drive start", drv_first, t_cmd + 1);
      chk(drv_n == DCYC, "R5", "drive length", drv_n, DCYC);
      chk(t_ack == t_cmd + DCYC + T_WR, "R5", "write ack cycle", t_ack, t_cmd + DCYC + T_WR);
      chk(cap_n == 0, "R5", "no capture on write", cap_n, 0);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pins_now() == P_NOP, "R1", "pins in reset", pins_now(), P_NOP);
    chk({rd_ack, wr_ack, ref_ack} == 3'b000, "R1", "acks in reset", {rd_ack, wr_ack, ref_ack}, 0);
    rst_n = 1'b1;
    host_req = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(pins_now() == P_NOP, "R1", "NOP before init", pins_now(), P_NOP);
      chk(!rd_ack && !wr_ack, "R1", "no ack before init", {rd_ack, wr_ack}, 0);
    end
    host_req = 1'b0;
    init_done = 1'b1;
    @(negedge clk);
    access(1'b0, 2'd0, 13'h0000, 10'h000);
    @(negedge clk);
    access(1'b1, 2'd3, 13'h1fff, 10'h3ff);
    @(negedge clk);
    access(1'b0, 2'd1, 13'h1555, 10'h2aa);
    @(negedge clk);
    access(1'b1, 2'd2, 13'h0aaa, 10'h155);
    // directed: refresh due in the same idle cycle as a host request
    do @(negedge clk); while (!ref_req);
    access(1'b0, 2'd2, 13'h0123, 10'h0ff);
    // back-to-back traffic across several refresh intervals
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      access(i[0], 2'(i), 13'(i * 37 + 5), 10'(i * 11 + 3));
    end
    chk(n_r9 > 0, "R9", "refresh during access exercised", n_r9, 1);
    @(negedge clk);
    idle_phase = 1'b1;
    repeat (4 * (REF_P + T_RFC)) @(negedge clk);
    idle_phase = 1'b0;
    chk(exp_q.size() == 0, "R6", "all commands observed", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule